// File: doc/BRIEF.md
# Multi-Cycle Fetch-Decode-Execute Sequencer

This block is the control unit of a small processor whose instructions and data live in one synchronous memory, reached through a single address path. It owns the program counter, memory address register, memory buffer register, instruction register and stack pointer. It walks each instruction through a fixed fetch sequence: the PC is copied into the address register, the memory is read into the buffer register, the buffer is copied into the instruction register, and the PC is advanced. It then decodes the instruction, performs an optional indirect operand read, and executes. The memory has a read latency of one cycle, so every read spends one state issuing the request and one state capturing the data.

Each 16-bit instruction word carries a 4-bit opcode in bits 15:12, a mode flag in bit 11 (0 = the 11-bit operand is used as the value itself, 1 = the operand is an address whose memory word is the value), and an 11-bit operand in bits 10:0. The arithmetic unit and accumulator sit outside the block. The sequencer only pulses their enables and presents the resolved operand value. A subroutine call saves the return address on a descending stack in the same memory, and a return restores it.

Opcodes: 0 no-op, 1 load accumulator, 2 store, 3 add, 4 subtract, 5 and, 6 jump, 7 call, 8 return. Values 9 to 15 behave as no-ops.

Top module: `fde_sequencer`

## Requirements
- R1: While reset is held, mem_rd, mem_we, dp_acc_ld and dp_alu_en are all 0. After reset the first memory read is the instruction fetch at address 0.
- R2: Each instruction fetch is a memory read at the current PC. With direct-mode instructions that do not touch memory, consecutive fetches are 7 cycles apart at addresses that increase by one.
- R3: A word with opcode field (bits 15:12) equal to 0 or to 9..15 causes no memory write, no datapath pulse and no operand read, whatever its mode bit (bit 11).
- R4: Load (opcode 1) in direct mode (bit 11 = 0) gives one dp_acc_ld pulse with dp_operand equal to bits 10:0 zero-extended. No extra memory read occurs, so the next fetch follows 7 cycles after this one.
- R5: In indirect mode (bit 11 = 1), an operand-using opcode (1..7) issues one extra read at address bits 10:0, 5 cycles after its own fetch read. The word read becomes the operand value.
- R6: Add (3), subtract (4) and and (5) each give a single-cycle dp_alu_en pulse with dp_alu_sel 0, 1 and 2 respectively, and dp_operand equal to the resolved operand.
- R7: Store (opcode 2) writes store_data once, at the low 11 bits of the resolved operand.
- R8: Jump (opcode 6) makes the next fetch happen at the low 11 bits of the resolved operand.
- R9: Call (opcode 7) decrements the stack pointer (reset value 0, so the first push goes to 0x7FF) and writes the return address (call address + 1) there. The next fetch is at the resolved target.
- R10: Return (opcode 8) reads the word at the stack pointer, then increments the stack pointer, and the next fetch is at that word's low 11 bits. Nested calls unwind in last-in first-out order.
- R11: mem_rd and mem_we are never 1 together, and dp_acc_ld and dp_alu_en are never 1 together.
- R12: Return ignores the mode bit: it issues no operand read before its stack read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 11 | Shared memory address (address register) |
| mem_rd | output | 1 | Read request; data is returned on mem_rdata in the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Read data from the synchronous memory |
| store_data | input | 16 | Value that a store instruction writes |
| dp_operand | output | 16 | Resolved operand value for the datapath |
| dp_acc_ld | output | 1 | Accumulator load enable |
| dp_alu_en | output | 1 | Arithmetic unit enable |
| dp_alu_sel | output | 2 | Arithmetic select: 0 add, 1 subtract, 2 and |

## Verification
A call does two things on one clock edge: the return address is captured for the stack push, and the program counter loads the subroutine target. Directed call scenarios in direct mode, indirect mode and nested form check that each pushed word equals the call address plus one and not the target, while the next fetch lands on the target. The return side checks that the popped address drives the following fetch and that a later push reuses the freed stack slot.

// File: rtl/fde_pkg.sv
package fde_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_NOP = 4'd0;
  localparam logic [OPW-1:0] OP_LDA = 4'd1;
  localparam logic [OPW-1:0] OP_STA = 4'd2;
  localparam logic [OPW-1:0] OP_ADD = 4'd3;
  localparam logic [OPW-1:0] OP_SUB = 4'd4;
  localparam logic [OPW-1:0] OP_AND = 4'd5;
  localparam logic [OPW-1:0] OP_JMP = 4'd6;
  localparam logic [OPW-1:0] OP_JSR = 4'd7;
  localparam logic [OPW-1:0] OP_RTS = 4'd8;

  localparam logic [1:0] SEL_ADD = 2'd0;
  localparam logic [1:0] SEL_SUB = 2'd1;
  localparam logic [1:0] SEL_AND = 2'd2;

  typedef enum logic [3:0] {
    ST_F_MAR, ST_F_RD, ST_F_MBR, ST_F_IR, ST_F_PC,
    ST_DEC, ST_I_RD, ST_I_MBR, ST_EX, ST_WR,
    ST_P_RD, ST_P_MBR, ST_P_PC
  } state_t;

  typedef struct packed {
    logic       acc_ld;
    logic       alu_en;
    logic [1:0] alu_sel;
    logic       uses_operand;
    logic       is_sta;
    logic       is_jmp;
    logic       is_jsr;
    logic       is_rts;
  } dec_t;

endpackage

// File: rtl/fde_rst_sync.sv
module fde_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/fde_decode.sv
module fde_decode
  import fde_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output dec_t           dec
);
  always_comb begin
    dec = '0;
    case (opcode)
      OP_LDA: begin dec.acc_ld = 1'b1; dec.uses_operand = 1'b1; end
      OP_STA: begin dec.is_sta = 1'b1; dec.uses_operand = 1'b1; end
      OP_ADD: begin dec.alu_en = 1'b1; dec.alu_sel = SEL_ADD; dec.uses_operand = 1'b1; end
      OP_SUB: begin dec.alu_en = 1'b1; dec.alu_sel = SEL_SUB; dec.uses_operand = 1'b1; end
      OP_AND: begin dec.alu_en = 1'b1; dec.alu_sel = SEL_AND; dec.uses_operand = 1'b1; end
      OP_JMP: begin dec.is_jmp = 1'b1; dec.uses_operand = 1'b1; end
      OP_JSR: begin dec.is_jsr = 1'b1; dec.uses_operand = 1'b1; end
      OP_RTS: dec.is_rts = 1'b1;
      default: dec = '0;  // no-op and undefined codes
    endcase
  end
endmodule

// File: rtl/fde_regs.sv
module fde_regs #(
  parameter int          DW       = 16,
  parameter int          AW       = 11,
  parameter logic [AW-1:0] PC_RESET = '0,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_inc,
  input  logic          pc_ld,
  input  logic [AW-1:0] pc_din,
  input  logic          mar_ld,
  input  logic [AW-1:0] mar_din,
  input  logic          mbr_ld,
  input  logic [DW-1:0] mbr_din,
  input  logic          ir_ld,
  input  logic          sp_dec,
  input  logic          sp_inc,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= PC_RESET;
    else if (pc_ld)  pc <= pc_din;
    else if (pc_inc) pc <= pc + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mar <= '0;
    else if (mar_ld) mar <= mar_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mbr <= '0;
    else if (mbr_ld) mbr <= mbr_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir <= '0;
    else if (ir_ld) ir <= mbr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp <= SP_RESET;
    else if (sp_dec) sp <= sp - ONE;
    else if (sp_inc) sp <= sp + ONE;
  end

  // R2: the IR is only loaded from a buffer that was filled the cycle before
  a_r2_ir_after_mbr: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |-> $past(mbr_ld));

  // R2: the PC advances only right after the IR load
  a_r2_pc_inc_after_ir: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |-> $past(ir_ld));
endmodule

// File: rtl/fde_ctrl.sv
module fde_ctrl
  import fde_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dec_t          dec,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] sp,
  input  logic [DW-1:0] mbr,
  input  logic [DW-1:0] ir,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] store_data,
  output logic          pc_inc,
  output logic          pc_ld,
  output logic [AW-1:0] pc_din,
  output logic          mar_ld,
  output logic [AW-1:0] mar_din,
  output logic          mbr_ld,
  output logic [DW-1:0] mbr_din,
  output logic          ir_ld,
  output logic          sp_dec,
  output logic          sp_inc,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [DW-1:0] operand,
  output logic          acc_ld,
  output logic          alu_en,
  output logic [1:0]    alu_sel
);
  localparam int MODE_BIT = DW - OPW - 1;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  state_t st, st_nxt;
  logic   indirect;
  logic [AW-1:0] sp_dn;

  assign indirect = ir[MODE_BIT];
  assign sp_dn    = sp - ONE;
  assign operand  = indirect ? mbr : {{(DW-AW){1'b0}}, ir[AW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_F_MAR;
    else        st <= st_nxt;
  end

  always_comb begin
    st_nxt  = st;
    pc_inc  = 1'b0;  pc_ld  = 1'b0;  pc_din  = '0;
    mar_ld  = 1'b0;  mar_din = '0;
    mbr_ld  = 1'b0;  mbr_din = '0;
    ir_ld   = 1'b0;  sp_dec = 1'b0;  sp_inc  = 1'b0;
    mem_rd  = 1'b0;  mem_we = 1'b0;
    acc_ld  = 1'b0;  alu_en = 1'b0;  alu_sel = '0;
    case (st)
      ST_F_MAR: begin mar_ld = 1'b1; mar_din = pc; st_nxt = ST_F_RD; end
      ST_F_RD:  begin mem_rd = 1'b1; st_nxt = ST_F_MBR; end
      ST_F_MBR: begin mbr_ld = 1'b1; mbr_din = mem_rdata; st_nxt = ST_F_IR; end
      ST_F_IR:  begin ir_ld = 1'b1; st_nxt = ST_F_PC; end
      ST_F_PC:  begin pc_inc = 1'b1; st_nxt = ST_DEC; end
      ST_DEC: begin
        if (dec.uses_operand && indirect) begin
          mar_ld  = 1'b1;
          mar_din = ir[AW-1:0];
          st_nxt  = ST_I_RD;
        end else begin
          st_nxt = ST_EX;
        end
      end
      ST_I_RD:  begin mem_rd = 1'b1; st_nxt = ST_I_MBR; end
      ST_I_MBR: begin mbr_ld = 1'b1; mbr_din = mem_rdata; st_nxt = ST_EX; end
      ST_EX: begin
        st_nxt  = ST_F_MAR;
        acc_ld  = dec.acc_ld;
        alu_en  = dec.alu_en;
        alu_sel = dec.alu_sel;
        if (dec.is_jmp) begin
          pc_ld  = 1'b1;
          pc_din = operand[AW-1:0];
        end
        if (dec.is_sta) begin
          mar_ld  = 1'b1; mar_din = operand[AW-1:0];
          mbr_ld  = 1'b1; mbr_din = store_data;
          st_nxt  = ST_WR;
        end
        if (dec.is_jsr) begin
          // return address captured and target loaded on the same edge
          sp_dec  = 1'b1;
          mar_ld  = 1'b1; mar_din = sp_dn;
          mbr_ld  = 1'b1; mbr_din = {{(DW-AW){1'b0}}, pc};
          pc_ld   = 1'b1; pc_din  = operand[AW-1:0];
          st_nxt  = ST_WR;
        end
        if (dec.is_rts) begin
          mar_ld  = 1'b1; mar_din = sp;
          st_nxt  = ST_P_RD;
        end
      end
      ST_WR:    begin mem_we = 1'b1; st_nxt = ST_F_MAR; end
      ST_P_RD:  begin mem_rd = 1'b1; st_nxt = ST_P_MBR; end
      ST_P_MBR: begin mbr_ld = 1'b1; mbr_din = mem_rdata; sp_inc = 1'b1; st_nxt = ST_P_PC; end
      ST_P_PC:  begin pc_ld = 1'b1; pc_din = mbr[AW-1:0]; st_nxt = ST_F_MAR; end
      default:  st_nxt = ST_F_MAR;
    endcase
  end

  // R11: one memory direction per cycle
  a_r11_rd_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  // R10: the stack pointer moves up only after the stack word was requested
  a_r10_pop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    sp_inc |-> $past(mem_rd));

  // R7 / R9: every write is preceded by a buffer load with the data
  a_r9_write_after_mbr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mbr_ld));
endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer
  import fde_pkg::*;
#(
  parameter int DW = 16,
  parameter int RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [DW-fde_pkg::OPW-2:0] mem_addr,
  output logic                  mem_rd,
  output logic                  mem_we,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  input  logic [DW-1:0]         store_data,
  output logic [DW-1:0]         dp_operand,
  output logic                  dp_acc_ld,
  output logic                  dp_alu_en,
  output logic [1:0]            dp_alu_sel
);
  localparam int AW = DW - OPW - 1;

  logic          rst_i_n;
  dec_t          dec;
  logic          pc_inc, pc_ld, mar_ld, mbr_ld, ir_ld, sp_dec, sp_inc;
  logic [AW-1:0] pc_din, mar_din, pc, mar, sp;
  logic [DW-1:0] mbr_din, mbr, ir;

  fde_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  fde_decode u_dec (
    .opcode(ir[DW-1 -: OPW]), .dec(dec)
  );

  fde_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .pc_inc(pc_inc), .pc_ld(pc_ld), .pc_din(pc_din),
    .mar_ld(mar_ld), .mar_din(mar_din),
    .mbr_ld(mbr_ld), .mbr_din(mbr_din),
    .ir_ld(ir_ld), .sp_dec(sp_dec), .sp_inc(sp_inc),
    .pc(pc), .mar(mar), .mbr(mbr), .ir(ir), .sp(sp)
  );

  fde_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .dec(dec),
    .pc(pc), .sp(sp), .mbr(mbr), .ir(ir),
    .mem_rdata(mem_rdata), .store_data(store_data),
    .pc_inc(pc_inc), .pc_ld(pc_ld), .pc_din(pc_din),
    .mar_ld(mar_ld), .mar_din(mar_din),
    .mbr_ld(mbr_ld), .mbr_din(mbr_din),
    .ir_ld(ir_ld), .sp_dec(sp_dec), .sp_inc(sp_inc),
    .mem_rd(mem_rd), .mem_we(mem_we),
    .operand(dp_operand), .acc_ld(dp_acc_ld),
    .alu_en(dp_alu_en), .alu_sel(dp_alu_sel)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;

  // R11: the datapath gets at most one enable per cycle
  a_r11_dp_onehot0: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({dp_acc_ld, dp_alu_en}));

  // R6: the arithmetic select only takes the three defined codes when enabled
  a_r6_sel_valid: assert property (@(posedge clk) disable iff (!rst_i_n)
    dp_alu_en |-> (dp_alu_sel != 2'd3));

  // R1: nothing reaches memory or datapath while the core is held in reset
  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_i_n |-> !(mem_rd || mem_we || dp_acc_ld || dp_alu_en));
endmodule

// File: tb/sim_fde_sequencer.sv
module sim_fde_sequencer;
  localparam int DW = 16;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata, store_data, dp_operand;
  logic          dp_acc_ld, dp_alu_en;
  logic [1:0]    dp_alu_sel;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] mem [0:(1<<AW)-1];

  int            cyc = 0;
  int            n_rd, n_wr, n_ev;
  logic [AW-1:0] rd_addr [0:255];
  int            rd_cyc  [0:255];
  logic [AW-1:0] wr_addr [0:255];
  logic [DW-1:0] wr_data [0:255];
  logic [1:0]    ev_kind [0:255];  // 1 = accumulator load, 2 = arithmetic
  logic [1:0]    ev_sel  [0:255];
  logic [DW-1:0] ev_val  [0:255];

  always #2 clk = ~clk;  // 250 MHz

  fde_sequencer u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .store_data(store_data), .dp_operand(dp_operand),
    .dp_acc_ld(dp_acc_ld), .dp_alu_en(dp_alu_en), .dp_alu_sel(dp_alu_sel)
  );

  // synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] = mem_wdata;
  end

  // bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mem_rd && n_rd < 256) begin
      rd_addr[n_rd] = mem_addr; rd_cyc[n_rd] = cyc; n_rd = n_rd + 1;
    end
    if (mem_we && n_wr < 256) begin
      wr_addr[n_wr] = mem_addr; wr_data[n_wr] = mem_wdata; n_wr = n_wr + 1;
    end
    if ((dp_acc_ld || dp_alu_en) && n_ev < 256) begin
      ev_kind[n_ev] = dp_acc_ld ? 2'd1 : 2'd2;
      ev_sel[n_ev]  = dp_alu_sel;
      ev_val[n_ev]  = dp_operand;
      n_ev = n_ev + 1;
    end
  end

  function automatic logic [DW-1:0] enc(input logic [3:0] op, input logic m, input logic [AW-1:0] a);
    return {op, m, a};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic start(input bit check_idle);
    rst_n = 1'b0;
    store_data = 16'hCAFE;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    if (check_idle) begin
      check("R1", "mem_rd in reset", 32'(mem_rd), 32'd0);
      check("R1", "mem_we in reset", 32'(mem_we), 32'd0);
      check("R1", "dp enables in reset", 32'({dp_acc_ld, dp_alu_en}), 32'd0);
    end
    n_rd = 0; n_wr = 0; n_ev = 0;
  endtask

  task automatic go(input int n);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_and_nops;
    start(1'b1);
    mem[4] = enc(4'hF, 1'b1, 11'h123);  // undefined code with mode bit set
    mem[5] = enc(4'h0, 1'b1, 11'h234);  // no-op with mode bit set
    go(60);
    check("R1", "first fetch address", 32'(rd_addr[0]), 32'd0);
    for (int i = 1; i < 7; i++)
      check("R2", "sequential fetch address", 32'(rd_addr[i]), 32'(i));
    check("R2", "fetch spacing", 32'(rd_cyc[1] - rd_cyc[0]), 32'd7);
    check("R3", "undefined op spacing", 32'(rd_cyc[5] - rd_cyc[4]), 32'd7);
    check("R3", "indirect no-op spacing", 32'(rd_cyc[6] - rd_cyc[5]), 32'd7);
    check("R3", "no writes", 32'(n_wr), 32'd0);
    check("R3", "no datapath pulses", 32'(n_ev), 32'd0);
  endtask

  task automatic t_load;
    start(1'b0);
    mem[0] = enc(4'h1, 1'b0, 11'h2AB);
    mem[1] = enc(4'h1, 1'b1, 11'h100);
    mem[11'h100] = 16'hBEEF;
    go(40);
    check("R4", "direct load kind", 32'(ev_kind[0]), 32'd1);
    check("R4", "direct load value", 32'(ev_val[0]), 32'h02AB);
    check("R4", "no extra read", 32'(rd_cyc[1] - rd_cyc[0]), 32'd7);
    check("R5", "indirect read address", 32'(rd_addr[2]), 32'h100);
    check("R5", "indirect read delay", 32'(rd_cyc[2] - rd_cyc[1]), 32'd5);
    check("R5", "indirect load value", 32'(ev_val[1]), 32'hBEEF);
    check("R5", "next fetch", 32'(rd_addr[3]), 32'd2);
  endtask

  task automatic t_alu;
    start(1'b0);
    mem[0] = enc(4'h3, 1'b0, 11'h005);
    mem[1] = enc(4'h4, 1'b1, 11'h200);
    mem[2] = enc(4'h5, 1'b0, 11'h7FF);
    mem[11'h200] = 16'h1234;
    go(40);
    check("R6", "event count", 32'(n_ev), 32'd3);
    check("R6", "add kind", 32'(ev_kind[0]), 32'd2);
    check("R6", "add select", 32'(ev_sel[0]), 32'd0);
    check("R6", "add value", 32'(ev_val[0]), 32'h0005);
    check("R6", "sub select", 32'(ev_sel[1]), 32'd1);
    check("R6", "sub value", 32'(ev_val[1]), 32'h1234);
    check("R6", "and select", 32'(ev_sel[2]), 32'd2);
    check("R6", "and value", 32'(ev_val[2]), 32'h07FF);
  endtask

  task automatic t_store;
    start(1'b0);
    mem[0] = enc(4'h2, 1'b0, 11'h345);
    mem[1] = enc(4'h2, 1'b1, 11'h300);
    mem[11'h300] = 16'hF456;
    go(40);
    check("R7", "write count", 32'(n_wr), 32'd2);
    check("R7", "direct store address", 32'(wr_addr[0]), 32'h345);
    check("R7", "direct store data", 32'(wr_data[0]), 32'hCAFE);
    check("R7", "indirect store address", 32'(wr_addr[1]), 32'h456);
    check("R7", "memory content", 32'(mem[11'h456]), 32'hCAFE);
    check("R11", "no datapath pulse", 32'(n_ev), 32'd0);
  endtask

  task automatic t_jump;
    start(1'b0);
    mem[0] = enc(4'h6, 1'b0, 11'h040);
    mem[11'h040] = enc(4'h6, 1'b1, 11'h050);
    mem[11'h050] = 16'h0123;
    go(40);
    check("R8", "direct jump target", 32'(rd_addr[1]), 32'h040);
    check("R8", "indirect pointer read", 32'(rd_addr[2]), 32'h050);
    check("R8", "indirect jump target", 32'(rd_addr[3]), 32'h123);
    check("R8", "after target", 32'(rd_addr[4]), 32'h124);
  endtask

  task automatic t_call_return;
    start(1'b0);
    mem[0] = enc(4'h7, 1'b0, 11'h080);
    mem[11'h080] = enc(4'h0, 1'b0, 11'h000);
    mem[11'h081] = enc(4'h8, 1'b1, 11'h000);  // return with mode bit set
    mem[1] = enc(4'h7, 1'b1, 11'h0F0);
    mem[11'h0F0] = 16'h0090;
    mem[11'h090] = enc(4'h8, 1'b0, 11'h000);
    go(90);
    check("R9", "first push address", 32'(wr_addr[0]), 32'h7FF);
    check("R9", "first push data", 32'(wr_data[0]), 32'd1);
    check("R9", "call target fetch", 32'(rd_addr[1]), 32'h080);
    check("R12", "no operand read on return", 32'(rd_addr[3]), 32'h7FF);
    check("R10", "return fetch", 32'(rd_addr[4]), 32'd1);
    check("R9", "indirect pointer read", 32'(rd_addr[5]), 32'h0F0);
    check("R10", "slot reused", 32'(wr_addr[1]), 32'h7FF);
    check("R9", "second push data", 32'(wr_data[1]), 32'd2);
    check("R9", "indirect target fetch", 32'(rd_addr[6]), 32'h090);
    check("R10", "second return fetch", 32'(rd_addr[8]), 32'd2);
  endtask

  task automatic t_nested;
    start(1'b0);
    mem[0] = enc(4'h7, 1'b0, 11'h010);
    mem[11'h010] = enc(4'h7, 1'b0, 11'h020);
    mem[11'h020] = enc(4'h8, 1'b0, 11'h000);
    mem[11'h011] = enc(4'h8, 1'b0, 11'h000);
    go(80);
    check("R9", "outer push", 32'(wr_addr[0]), 32'h7FF);
    check("R9", "inner push address", 32'(wr_addr[1]), 32'h7FE);
    check("R9", "inner push data", 32'(wr_data[1]), 32'h011);
    check("R10", "inner pop address", 32'(rd_addr[3]), 32'h7FE);
    check("R10", "inner return fetch", 32'(rd_addr[4]), 32'h011);
    check("R10", "outer pop address", 32'(rd_addr[5]), 32'h7FF);
    check("R10", "outer return fetch", 32'(rd_addr[6]), 32'd1);
  endtask

  initial begin
    t_reset_and_nops();
    t_load();
    t_alu();
    t_store();
    t_jump();
    t_call_return();
    t_nested();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule